// File: doc/BRIEF.md
# Saturated Function Composition Unit

A saturating add can be described as a clip function: it adds an offset `x` to its argument, then bounds the result from below by `lo` and from above by `hi`, giving y → min(max(y + x, lo), hi). Two such functions applied one after the other are again a function of the same shape. This block takes an earlier function A and a later function B, each as a triple (offset, lo, hi), and returns the triple of "B applied after A". Because this merge is associative, a prefix tree of these units can evaluate a long chain of saturating additions without a single-cycle feedback loop. Building the tree is not part of this block.

The offset of the composite is the plain sum of the two offsets, carried in W+2 bits. Both composite bounds are the earlier bounds shifted by the later offset and then clipped to B's range. As a result, each bound stays inside [B.lo, B.hi] and fits in W bits. When the composite bounds are equal, the function is a constant. Its offset is then irrelevant, and a wrap of that offset is harmless.

The work is split over two register stages. The first stage forms the three sums in widened arithmetic. The second stage clips the two bound sums against B's bounds. A valid flag travels alongside the data.

Top module: `satc_compose`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0 and `out_ofs`, `out_lo` and `out_hi` are 0, whatever `in_valid` does during reset.
- R2: `out_valid` equals the value that `in_valid` had two clock cycles earlier.
- R3: For an accepted input pair, `out_ofs` equals `a_ofs + b_ofs`, taken modulo 2^(W+2) as a two's complement value.
- R4: For an accepted pair, `out_hi` equals min(max(a_hi + b_ofs, b_lo), b_hi), computed without any wrap. This holds even when b_ofs is at its W+2-bit extremes.
- R5: For an accepted pair, `out_lo` equals min(max(a_lo + b_ofs, b_lo), b_hi), computed without any wrap.
- R6: When both inputs satisfy lo ≤ hi, every valid output satisfies b_lo ≤ out_lo ≤ out_hi ≤ b_hi.
- R7: If either input has lo equal to hi, the composite has `out_lo` equal to `out_hi`.
- R8: The following holds for any inputs whose offsets have magnitude at most 2^W − 1 and whose bounds are ordered W-bit values. For every integer y, applying the output triple to y gives the same value as applying A to y and then B to that result. For constant composites only this output value is compared.
- R9: With W = 8, compose A = B = (−254, −128, 127). The result is offset −508, lo −128 and hi −127, which is not a constant. Applied to 380 it gives −128, and applied to 381 it gives −127.
- R10: While `out_valid` is 0, `out_ofs`, `out_lo` and `out_hi` keep their previous values. Input values presented with `in_valid` low have no effect on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair is valid this cycle |
| a_ofs | input | W+2 | Offset of earlier function A (signed) |
| a_lo | input | W | Lower bound of A (signed) |
| a_hi | input | W | Upper bound of A (signed) |
| b_ofs | input | W+2 | Offset of later function B (signed) |
| b_lo | input | W | Lower bound of B (signed) |
| b_hi | input | W | Upper bound of B (signed) |
| out_valid | output | 1 | Composite triple is valid |
| out_ofs | output | W+2 | Offset of B after A (signed) |
| out_lo | output | W | Lower bound of B after A (signed) |
| out_hi | output | W | Upper bound of B after A (signed) |

## Verification
The assertions check several properties on every cycle:
- the two-cycle alignment of the valid flag;
- the offset sum;
- containment of both output bounds within the later function's range;
- their ordering;
- the collapse to a constant whenever either input was constant;
- the holding of outputs on idle cycles.

Only the bench scenarios can show the following:
- the exact clipped bound values, including the extreme offsets that need the extra guard bit;
- the equivalence of the composite with sequential application over many argument values;
- the specific tight-width example with offset −508.

// File: rtl/satc_pkg.sv
package satc_pkg;

    // Extra bits carried by the offset beyond the bound width.
    localparam int OFS_GUARD = 2;

    // Extra bit on top of the offset width, used for bound sums so that
    // a W-bit bound plus a full-range offset can never wrap.
    localparam int SUM_GUARD = 1;

    // Positions of the two bound lanes in the clip array.
    localparam int LANE_LO = 0;
    localparam int LANE_HI = 1;
    localparam int LANES   = 2;

endpackage

// File: rtl/satc_sum_stage.sv
module satc_sum_stage
    import satc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               in_valid,
    input  logic signed [W+OFS_GUARD-1:0]      a_ofs,
    input  logic signed [W-1:0]                a_lo,
    input  logic signed [W-1:0]                a_hi,
    input  logic signed [W+OFS_GUARD-1:0]      b_ofs,
    input  logic signed [W-1:0]                b_lo,
    input  logic signed [W-1:0]                b_hi,
    output logic                               s1_valid,
    output logic signed [W+OFS_GUARD-1:0]      s1_ofs,
    output logic signed [W+OFS_GUARD+SUM_GUARD-1:0] s1_lo_sum,
    output logic signed [W+OFS_GUARD+SUM_GUARD-1:0] s1_hi_sum,
    output logic signed [W-1:0]                s1_b_lo,
    output logic signed [W-1:0]                s1_b_hi
);
    localparam int OW = W + OFS_GUARD;
    localparam int SW = OW + SUM_GUARD;

    logic signed [SW-1:0] ext_a_lo, ext_a_hi, ext_b_ofs;

    always_comb begin
        ext_a_lo  = {{(SW-W){a_lo[W-1]}}, a_lo};
        ext_a_hi  = {{(SW-W){a_hi[W-1]}}, a_hi};
        ext_b_ofs = {{(SW-OW){b_ofs[OW-1]}}, b_ofs};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid  <= 1'b0;
            s1_ofs    <= '0;
            s1_lo_sum <= '0;
            s1_hi_sum <= '0;
            s1_b_lo   <= '0;
            s1_b_hi   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_ofs    <= a_ofs + b_ofs;
                s1_lo_sum <= ext_a_lo + ext_b_ofs;
                s1_hi_sum <= ext_a_hi + ext_b_ofs;
                s1_b_lo   <= b_lo;
                s1_b_hi   <= b_hi;
            end
        end
    end
endmodule

// File: rtl/satc_bound_clip.sv
module satc_bound_clip #(
    parameter int W  = 8,
    parameter int SW = 11
) (
    input  logic signed [SW-1:0] sum_i,
    input  logic signed [W-1:0]  lo_i,
    input  logic signed [W-1:0]  hi_i,
    output logic signed [W-1:0]  res_o
);
    logic signed [SW-1:0] lo_x, hi_x;
    logic below, above, inverted;

    always_comb begin
        lo_x     = {{(SW-W){lo_i[W-1]}}, lo_i};
        hi_x     = {{(SW-W){hi_i[W-1]}}, hi_i};
        below    = sum_i < lo_x;
        above    = sum_i > hi_x;
        inverted = lo_x > hi_x;
        // min(max(sum, lo), hi)
        if (below)
            res_o = inverted ? hi_i : lo_i;
        else if (above)
            res_o = hi_i;
        else
            res_o = sum_i[W-1:0];
    end
endmodule

// File: rtl/satc_compose.sv
module satc_compose
    import satc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic signed [W+OFS_GUARD-1:0] a_ofs,
    input  logic signed [W-1:0]           a_lo,
    input  logic signed [W-1:0]           a_hi,
    input  logic signed [W+OFS_GUARD-1:0] b_ofs,
    input  logic signed [W-1:0]           b_lo,
    input  logic signed [W-1:0]           b_hi,
    output logic                          out_valid,
    output logic signed [W+OFS_GUARD-1:0] out_ofs,
    output logic signed [W-1:0]           out_lo,
    output logic signed [W-1:0]           out_hi
);
    localparam int OW = W + OFS_GUARD;
    localparam int SW = OW + SUM_GUARD;

    typedef struct packed {
        logic signed [OW-1:0] ofs;
        logic signed [W-1:0]  lo;
        logic signed [W-1:0]  hi;
    } clip_fn_t;

    logic                 s1_valid;
    logic signed [OW-1:0] s1_ofs;
    logic signed [SW-1:0] s1_lo_sum, s1_hi_sum;
    logic signed [W-1:0]  s1_b_lo, s1_b_hi;

    satc_sum_stage #(.W(W)) u_sum (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .a_ofs    (a_ofs),
        .a_lo     (a_lo),
        .a_hi     (a_hi),
        .b_ofs    (b_ofs),
        .b_lo     (b_lo),
        .b_hi     (b_hi),
        .s1_valid (s1_valid),
        .s1_ofs   (s1_ofs),
        .s1_lo_sum(s1_lo_sum),
        .s1_hi_sum(s1_hi_sum),
        .s1_b_lo  (s1_b_lo),
        .s1_b_hi  (s1_b_hi)
    );

    logic [LANES-1:0][SW-1:0] lane_sum;
    logic [LANES-1:0][W-1:0]  lane_res;

    always_comb begin
        lane_sum[LANE_LO] = s1_lo_sum;
        lane_sum[LANE_HI] = s1_hi_sum;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        satc_bound_clip #(.W(W), .SW(SW)) u_clip (
            .sum_i(lane_sum[k]),
            .lo_i (s1_b_lo),
            .hi_i (s1_b_hi),
            .res_o(lane_res[k])
        );
    end

    clip_fn_t fn_q;
    logic     valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            fn_q    <= '0;
        end else begin
            valid_q <= s1_valid;
            if (s1_valid) begin
                fn_q.ofs <= s1_ofs;
                fn_q.lo  <= lane_res[LANE_LO];
                fn_q.hi  <= lane_res[LANE_HI];
            end
        end
    end

    assign out_valid = valid_q;
    assign out_ofs   = fn_q.ofs;
    assign out_lo    = fn_q.lo;
    assign out_hi    = fn_q.hi;
endmodule

// File: rtl/satc_compose_chk.sv
module satc_compose_chk
    import satc_pkg::*;
#(
    parameter int W = 8
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          in_valid,
    input logic signed [W+OFS_GUARD-1:0] a_ofs,
    input logic signed [W-1:0]           a_lo,
    input logic signed [W-1:0]           a_hi,
    input logic signed [W+OFS_GUARD-1:0] b_ofs,
    input logic signed [W-1:0]           b_lo,
    input logic signed [W-1:0]           b_hi,
    input logic                          out_valid,
    input logic signed [W+OFS_GUARD-1:0] out_ofs,
    input logic signed [W-1:0]           out_lo,
    input logic signed [W-1:0]           out_hi
);
    localparam int OW = W + OFS_GUARD;

    logic                 p1_v, p2_v, p1_c, p2_c;
    logic signed [OW-1:0] p1_ofs, p2_ofs;
    logic signed [W-1:0]  p1_blo, p2_blo, p1_bhi, p2_bhi;

    always_ff @(posedge clk) begin
        if (rst) begin
            p1_v <= 1'b0; p2_v <= 1'b0; p1_c <= 1'b0; p2_c <= 1'b0;
            p1_ofs <= '0; p2_ofs <= '0;
            p1_blo <= '0; p2_blo <= '0; p1_bhi <= '0; p2_bhi <= '0;
        end else begin
            p1_v <= in_valid;
            p2_v <= p1_v;
            if (in_valid) begin
                p1_ofs <= a_ofs + b_ofs;
                p1_blo <= b_lo;
                p1_bhi <= b_hi;
                p1_c   <= (a_lo == a_hi) || (b_lo == b_hi);
            end
            if (p1_v) begin
                p2_ofs <= p1_ofs;
                p2_blo <= p1_blo;
                p2_bhi <= p1_bhi;
                p2_c   <= p1_c;
            end
        end
    end

    // R2: valid flag delayed by exactly two cycles
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid == p2_v);

    // R3: composed offset is the wrapped sum of the two offsets
    assert_ofs_sum_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_ofs == p2_ofs);

    // R6: both bounds stay inside the later function's range, ordered
    assert_bounds_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_lo >= p2_blo && out_hi <= p2_bhi && out_lo <= out_hi));

    // R7: a constant input yields a constant composite
    assert_const_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && p2_c) |-> out_lo == out_hi);

    // R10: outputs hold while no valid result is presented
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable({out_ofs, out_lo, out_hi}));
endmodule

bind satc_compose satc_compose_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .a_ofs    (a_ofs),
    .a_lo     (a_lo),
    .a_hi     (a_hi),
    .b_ofs    (b_ofs),
    .b_lo     (b_lo),
    .b_hi     (b_hi),
    .out_valid(out_valid),
    .out_ofs  (out_ofs),
    .out_lo   (out_lo),
    .out_hi   (out_hi)
);

// File: tb/satc_compose_bench.sv
module satc_compose_bench;
    localparam int W  = 8;
    localparam int OW = W + 2;
    localparam int BMIN = -(1 << (W-1));
    localparam int BMAX = (1 << (W-1)) - 1;
    localparam int DMAX = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [OW-1:0] a_ofs = '0, b_ofs = '0;
    logic signed [W-1:0]  a_lo = '0, a_hi = '0, b_lo = '0, b_hi = '0;
    logic                 out_valid;
    logic signed [OW-1:0] out_ofs;
    logic signed [W-1:0]  out_lo, out_hi;

    always #4 clk = ~clk;

    satc_compose #(.W(W)) u_satc_compose (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_ofs(a_ofs), .a_lo(a_lo), .a_hi(a_hi),
        .b_ofs(b_ofs), .b_lo(b_lo), .b_hi(b_hi),
        .out_valid(out_valid), .out_ofs(out_ofs),
        .out_lo(out_lo), .out_hi(out_hi)
    );

    typedef struct {
        bit v;
        bit special;
        int ao, al, ah, bo, bl, bh;
    } stim_t;

    stim_t q[$];
    int n_checks = 0;
    int n_errors = 0;
    int h_ofs = 0, h_lo = 0, h_hi = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clipi(input int v, input int lo, input int hi);
        int t;
        t = (v < lo) ? lo : v;
        return (t > hi) ? hi : t;
    endfunction

    function automatic int applyf(input int y, input int x, input int lo, input int hi);
        return clipi(y + x, lo, hi);
    endfunction

    function automatic int wrap_ofs(input int v);
        logic signed [OW-1:0] t;
        t = OW'(v);
        return int'(t);
    endfunction

    function automatic int rr(input int lo, input int hi);
        return lo + int'($urandom_range(hi - lo));
    endfunction

    task automatic check_front();
        stim_t s;
        int eo, el, eh, go, gl, gh, bad_y, got, ref_v;
        s = q.pop_front();
        go = int'(out_ofs); gl = int'(out_lo); gh = int'(out_hi);
        chk("R2 out_valid", int'(out_valid), int'(s.v));
        if (!s.v) begin
            chk("R10 idle ofs hold", go, h_ofs);
            chk("R10 idle lo hold", gl, h_lo);
            chk("R10 idle hi hold", gh, h_hi);
            return;
        end
        eo = wrap_ofs(s.ao + s.bo);
        el = clipi(s.al + s.bo, s.bl, s.bh);
        eh = clipi(s.ah + s.bo, s.bl, s.bh);
        chk("R3 ofs", go, eo);
        chk("R4 hi", gh, eh);
        chk("R5 lo", gl, el);
        chk("R6 in range", int'(gl >= s.bl && gh <= s.bh && gl <= gh), 1);
        if (s.al == s.ah || s.bl == s.bh)
            chk("R7 constant", gl, gh);
        bad_y = 0;
        for (int k = 0; k < 12; k++) begin
            int y;
            y = (k < 6) ? (k - 3) * (1 << W) : rr(-3 * (1 << W), 3 * (1 << W));
            ref_v = applyf(applyf(y, s.ao, s.al, s.ah), s.bo, s.bl, s.bh);
            got   = applyf(y, go, gl, gh);
            if (got != ref_v && bad_y == 0) begin
                bad_y = 1;
                chk("R8 equivalence", got, ref_v);
            end
        end
        if (bad_y == 0) chk("R8 equivalence", 0, 0);
        if (s.special) begin
            chk("R9 ofs -508", go, -508);
            chk("R9 lo", gl, -128);
            chk("R9 hi", gh, -127);
            chk("R9 y=380", applyf(380, go, gl, gh), -128);
            chk("R9 y=381", applyf(381, go, gl, gh), -127);
        end
        h_ofs = go; h_lo = gl; h_hi = gh;
    endtask

    task automatic step(input stim_t s);
        @(negedge clk);
        check_front();
        in_valid = s.v;
        a_ofs = OW'(s.ao); a_lo = W'(s.al); a_hi = W'(s.ah);
        b_ofs = OW'(s.bo); b_lo = W'(s.bl); b_hi = W'(s.bh);
        q.push_back(s);
    endtask

    function automatic stim_t mk(input int ao, input int al, input int ah,
                                 input int bo, input int bl, input int bh);
        stim_t s;
        s.v = 1; s.special = 0;
        s.ao = ao; s.al = al; s.ah = ah; s.bo = bo; s.bl = bl; s.bh = bh;
        return s;
    endfunction

    function automatic stim_t idle_garbage();
        stim_t s;
        s = mk(rr(-512, 511), rr(BMIN, BMAX), rr(BMIN, BMAX),
               rr(-512, 511), rr(BMIN, BMAX), rr(BMIN, BMAX));
        s.v = 0;
        return s;
    endfunction

    function automatic stim_t rnd_valid();
        stim_t s;
        int al, ah, bl, bh;
        al = rr(BMIN, BMAX);
        ah = ($urandom_range(7) == 0) ? al : rr(al, BMAX);
        bl = rr(BMIN, BMAX);
        bh = ($urandom_range(7) == 0) ? bl : rr(bl, BMAX);
        if ($urandom_range(9) == 0) begin bl = BMIN; bh = BMAX; end
        s = mk(rr(-DMAX, DMAX), al, ah, rr(-DMAX, DMAX), bl, bh);
        return s;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        stim_t s;
        // R1: reset holds everything at zero even with in_valid high
        repeat (2) @(negedge clk);
        in_valid = 1'b1; a_ofs = 10'sd5; b_ofs = 10'sd7;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", int'(out_valid), 0);
        chk("R1 reset ofs", int'(out_ofs), 0);
        chk("R1 reset lo", int'(out_lo), 0);
        chk("R1 reset hi", int'(out_hi), 0);
        rst = 1'b0;
        in_valid = 1'b0;
        s = idle_garbage();
        q.push_back(s);
        q.push_back(s);
        @(posedge clk);
        #1;
        chk("R1 first cycle valid", int'(out_valid), 0);

        // R9: tight-width example
        s = mk(-254, -128, 127, -254, -128, 127);
        s.special = 1;
        step(s);
        // R4 R5: full-range offset extremes through identity A
        step(mk(0, BMIN, BMAX, 511, -100, 50));
        step(mk(0, BMIN, BMAX, -512, -100, 50));
        step(mk(0, BMIN, BMAX, 0, BMIN, BMAX));
        // R7: constant earlier, then constant later
        step(mk(37, 20, 20, -5, -60, 90));
        step(mk(-100, BMIN, 10, 44, -3, -3));
        // R10: idle cycles with random garbage on the inputs
        for (int k = 0; k < 4; k++) step(idle_garbage());
        // back-to-back valid, then mixed random traffic
        step(mk(255, BMIN, BMAX, -255, 0, 0));
        step(mk(-255, 127, 127, 255, BMIN, BMAX));
        for (int k = 0; k < 800; k++) begin
            if ($urandom_range(3) == 0) step(idle_garbage());
            else step(rnd_valid());
        end
        step(idle_garbage());
        step(idle_garbage());
        step(idle_garbage());
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule